// File: doc/BRIEF.md
# I2S Stereo Receiver with Word-Length Detection

This block turns a stereo I2S stream into parallel audio samples. The bit clock, word select and serial data lines come in as plain inputs. A faster system clock samples them, and the block does all of its work in that clock domain. Each channel word is captured MSB first. Any bits the transmitter did not send are filled with zeros, so a word of 16 to 24 bits always appears MSB-aligned in a 24-bit sample. When a stereo frame is complete, both samples are presented together with a one-cycle valid strobe.

The block also counts bit clocks between successive frame starts and flags a frame whose length is wrong. It works out the transmitter's active word length from the data itself: over a window of good frames, it finds the deepest bit position that carried a one, and reports that position clamped to the supported range. Downstream logic uses the samples directly. The word length and the framing flag serve as stream-health information.

Top module: `i2srx_top`

## Requirements
- R1: While reset is asserted and until the first complete frame, left_o and right_o are zero, valid_o and frame_err_o are low, and word_len_o is 24.
- R2: A left word is sent while word select is low (0). Its MSB is the bit sampled at the second bit-clock rising edge after word select falls, and it lands in left_o[23]. Later bits fill the lower positions in order.
- R3: A right word is sent while word select is high (1). Its MSB is the bit sampled at the second bit-clock rising edge after word select rises, and it lands in right_o[23].
- R4: A word shorter than 24 bits has its missing low bits set to zero in the output. Bits beyond the 24th of a word are ignored.
- R5: A frame runs from one falling edge of word select to the next. Each good frame produces exactly one valid_o pulse of one system-clock cycle, and left_o and right_o change only in that cycle.
- R6: A frame is good when exactly 64 bit-clock rising edges are counted from one word-select fall up to, but not including, the next. The split between the two halves does not matter. A frame of any other length pulses frame_err_o for one cycle instead of valid_o, and leaves the samples unchanged. The first fall after reset only starts framing.
- R7: After every 4 good frames, word_len_o takes the value max(16, P), where P is the largest position counted 1 at the MSB through 24 at the LSB that held a one in any sample of those frames. P is 0 for all-zero data. Error frames do not count toward a window. word_len_o changes only in the cycle after a valid_o pulse.
- R8: valid_o and frame_err_o are never high together, and word_len_o always lies between 16 and 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| ws_i | input | 1 | Word select: 0 for the left channel, 1 for the right |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, MSB-aligned, zero-filled |
| right_o | output | 24 | Right sample, MSB-aligned, zero-filled |
| valid_o | output | 1 | One-cycle strobe when a good frame's samples are presented |
| frame_err_o | output | 1 | One-cycle strobe for a frame with the wrong bit-clock count |
| word_len_o | output | 5 | Detected word length, 16 to 24 |

## Verification
The bound checker enforces four rules on every cycle. The valid and error strobes last one cycle and never occur together. The samples hold still outside a valid strobe. The detected length stays in range and moves only right after a valid strobe. The bench scenarios cover what no single-cycle property can show: which serial bits end up at which sample positions, zero filling and truncation, which frame lengths count as good, and how the detected length follows the deepest set bit over a window that error frames do not advance.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

    // One bit-clock event as seen in the system clock domain
    typedef struct packed {
        logic rise;  // bit clock rising edge detected this cycle
        logic ws;    // synchronized word select at that edge
        logic sd;    // synchronized serial data at that edge
    } bit_evt_t;

    localparam int unsigned CH_LEFT  = 0;
    localparam int unsigned CH_RIGHT = 1;
    localparam int unsigned CH_COUNT = 2;

endpackage

// File: rtl/i2srx_sync.sv
module i2srx_sync
    import i2srx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_i,
    input  logic     ws_i,
    input  logic     sd_i,
    output bit_evt_t evt_o
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] ws;
        logic [STAGES-1:0] sd;
        logic              sck_last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sck      = {st_q.sck[STAGES-2:0], sck_i};
        st_d.ws       = {st_q.ws[STAGES-2:0], ws_i};
        st_d.sd       = {st_q.sd[STAGES-2:0], sd_i};
        st_d.sck_last = st_q.sck[STAGES-1];

        evt_o.rise = st_q.sck[STAGES-1] & ~st_q.sck_last;
        evt_o.ws   = st_q.ws[STAGES-1];
        evt_o.sd   = st_q.sd[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/i2srx_framer.sv
module i2srx_framer
    import i2srx_pkg::*;
#(
    parameter int FRAME_LEN = 64,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bit_evt_t         evt_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [1:0]       clr_o,
    output logic [1:0]       we_o,
    output logic             sd_o,
    output logic             frame_end_o,
    output logic             frame_ok_o
);

    typedef struct packed {
        logic             ws_last;
        logic             armed;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic    ws_edge;

    always_comb begin
        st_d        = st_q;
        clr_o       = '0;
        we_o        = '0;
        frame_end_o = 1'b0;
        frame_ok_o  = 1'b0;
        ws_edge     = evt_i.ws ^ st_q.ws_last;

        if (evt_i.rise) begin
            st_d.ws_last = evt_i.ws;

            // slot index within the current channel half
            if (ws_edge) begin
                st_d.idx            = '0;
                clr_o[evt_i.ws]     = 1'b1;
            end else begin
                if (st_q.idx != '1) begin
                    st_d.idx = st_q.idx + 1'b1;
                end
                we_o[evt_i.ws] = 1'b1;
            end

            // frame length bookkeeping between word-select falls
            if (ws_edge && !evt_i.ws) begin
                frame_end_o = st_q.armed;
                frame_ok_o  = (st_q.cnt == CNT_W'(FRAME_LEN));
                st_d.cnt    = CNT_W'(1);
                st_d.armed  = 1'b1;
            end else if (st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        idx_o = st_d.idx;
        sd_o  = evt_i.sd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/i2srx_chan.sv
module i2srx_chan #(
    parameter int SAMPLE_W = 24,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                we_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                sd_i,
    output logic [SAMPLE_W-1:0] word_o
);

    logic [SAMPLE_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clr_i) begin
            word_d = '0;
        end else if (we_i) begin
            // slot 1 is the MSB; slots past SAMPLE_W match no bit
            for (int b = 0; b < SAMPLE_W; b++) begin
                if (idx_i == IDX_W'(SAMPLE_W - b)) begin
                    word_d[b] = sd_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/i2srx_wlen.sv
module i2srx_wlen #(
    parameter int SAMPLE_W   = 24,
    parameter int MIN_WLEN   = 16,
    parameter int WIN_FRAMES = 4,
    parameter int WL_W       = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic [WL_W-1:0]     wlen_o
);

    localparam int WC_W = $clog2(WIN_FRAMES) + 1;

    typedef struct packed {
        logic [WL_W-1:0] acc;
        logic [WC_W-1:0] cnt;
        logic [WL_W-1:0] wl;
    } wl_st_t;

    wl_st_t          st_d, st_q;
    logic [WL_W-1:0] pos_l, pos_r, frame_pos, peak;

    // position (1 = MSB) of the lowest set bit, 0 when none is set
    function automatic logic [WL_W-1:0] low_pos(input logic [SAMPLE_W-1:0] w);
        logic [WL_W-1:0] p;
        p = '0;
        for (int b = SAMPLE_W - 1; b >= 0; b--) begin
            if (w[b]) begin
                p = WL_W'(SAMPLE_W - b);
            end
        end
        return p;
    endfunction

    always_comb begin
        st_d      = st_q;
        pos_l     = low_pos(left_i);
        pos_r     = low_pos(right_i);
        frame_pos = (pos_l > pos_r) ? pos_l : pos_r;
        peak      = (frame_pos > st_q.acc) ? frame_pos : st_q.acc;

        if (stb_i) begin
            if (st_q.cnt == WC_W'(WIN_FRAMES - 1)) begin
                st_d.wl  = (peak < WL_W'(MIN_WLEN)) ? WL_W'(MIN_WLEN) : peak;
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = peak;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.wl  <= WL_W'(SAMPLE_W);
        end else begin
            st_q <= st_d;
        end
    end

    assign wlen_o = st_q.wl;

endmodule

// File: rtl/i2srx_top.sv
module i2srx_top
    import i2srx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int MIN_WLEN    = 16,
    parameter int FRAME_LEN   = 64,
    parameter int WIN_FRAMES  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int WL_W       = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck_i,
    input  logic                ws_i,
    input  logic                sd_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                frame_err_o,
    output logic [WL_W-1:0]     word_len_o
);

    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam int CNT_W = $clog2(FRAME_LEN) + 2;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
        logic                err;
    } out_st_t;

    bit_evt_t            evt;
    logic [IDX_W-1:0]    idx;
    logic [1:0]          clr, we;
    logic                sd_bit, frame_end, frame_ok;
    logic [SAMPLE_W-1:0] words [CH_COUNT];
    out_st_t             out_d, out_q;

    i2srx_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_i (sck_i),
        .ws_i  (ws_i),
        .sd_i  (sd_i),
        .evt_o (evt)
    );

    i2srx_framer #(
        .FRAME_LEN (FRAME_LEN),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) framer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .idx_o       (idx),
        .clr_o       (clr),
        .we_o        (we),
        .sd_o        (sd_bit),
        .frame_end_o (frame_end),
        .frame_ok_o  (frame_ok)
    );

    for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
        i2srx_chan #(
            .SAMPLE_W (SAMPLE_W),
            .IDX_W    (IDX_W)
        ) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr[ch]),
            .we_i   (we[ch]),
            .idx_i  (idx),
            .sd_i   (sd_bit),
            .word_o (words[ch])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        out_d.err   = 1'b0;
        if (frame_end) begin
            if (frame_ok) begin
                out_d.left  = words[CH_LEFT];
                out_d.right = words[CH_RIGHT];
                out_d.valid = 1'b1;
            end else begin
                out_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    i2srx_wlen #(
        .SAMPLE_W   (SAMPLE_W),
        .MIN_WLEN   (MIN_WLEN),
        .WIN_FRAMES (WIN_FRAMES),
        .WL_W       (WL_W)
    ) wlen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (out_q.valid),
        .left_i  (out_q.left),
        .right_i (out_q.right),
        .wlen_o  (word_len_o)
    );

    assign left_o      = out_q.left;
    assign right_o     = out_q.right;
    assign valid_o     = out_q.valid;
    assign frame_err_o = out_q.err;

endmodule

// File: rtl/i2srx_chk.sv
module i2srx_chk #(
    parameter int SAMPLE_W = 24,
    parameter int MIN_WLEN = 16,
    parameter int WL_W     = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                valid_o,
    input logic                frame_err_o,
    input logic [WL_W-1:0]     word_len_o
);

    // R8
    no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && frame_err_o));

    // R8
    wlen_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_len_o >= WL_W'(MIN_WLEN)) && (word_len_o <= WL_W'(SAMPLE_W)));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);

    // R5
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R7
    wlen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_o) |-> $stable(word_len_o));

endmodule

bind i2srx_top i2srx_chk #(
    .SAMPLE_W (SAMPLE_W),
    .MIN_WLEN (MIN_WLEN),
    .WL_W     (WL_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o),
    .word_len_o  (word_len_o)
);

// File: tb/i2srx_top_tb_top.sv
module i2srx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 3;
    localparam int SW         = 24;
    localparam int MINW       = 16;
    localparam int WIN        = 4;
    localparam int FL         = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        ws = 1'b1;
    logic        sd = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o, frame_err_o;
    logic [4:0]  word_len_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2srx_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (sck),
        .ws_i        (ws),
        .sd_i        (sd),
        .left_o      (left_o),
        .right_o     (right_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o),
        .word_len_o  (word_len_o)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          running = 1'b0;
    logic [23:0] q_l[$];
    logic [23:0] q_r[$];
    bit          q_ok[$];
    string       q_tl[$];
    string       q_tr[$];
    logic [23:0] last_l = '0;
    logic [23:0] last_r = '0;
    int          exp_wl = SW;
    int          win_cnt = 0;
    int          win_max = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(input logic [31:0] v, input int nb);
        logic [23:0] w;
        w = '0;
        for (int k = 1; k <= SW; k++) begin
            if (k <= nb) w[SW-k] = v[nb-k];
        end
        return w;
    endfunction

    function automatic int low_pos(input logic [23:0] w);
        int p;
        p = 0;
        for (int b = SW - 1; b >= 0; b--) begin
            if (w[b]) p = SW - b;
        end
        return p;
    endfunction

    task automatic slot(input bit w, input bit d);
        @(negedge clk);
        sck = 1'b0;
        ws  = w;
        sd  = d;
        repeat (HB) @(negedge clk);
        sck = 1'b1;
        repeat (HB - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] lv, input logic [31:0] rv,
                              input int nb, input int lsl, input int rsl);
        for (int s = 0; s < lsl + rsl; s++) begin
            bit          w;
            int          k;
            logic [31:0] v;
            bit          d;
            w = (s >= lsl);
            k = w ? s - lsl : s;
            v = w ? rv : lv;
            d = (k >= 1 && k <= nb) ? v[nb-k] : 1'b0;
            slot(w, d);
        end
        q_l.push_back(exp_word(lv, nb));
        q_r.push_back(exp_word(rv, nb));
        q_ok.push_back(lsl + rsl == FL);
        q_tl.push_back(nb == SW ? "R2" : "R4");
        q_tr.push_back(nb == SW ? "R3" : "R4");
    endtask

    // output monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (running && (valid_o || frame_err_o)) begin
            if (q_ok.size() == 0) begin
                check(1'b0, "R5", "event with no pending frame", valid_o, 0);
            end else begin
                logic [23:0] el, er;
                bit          ok;
                string       tl, tr;
                int          fp;
                el = q_l.pop_front();
                er = q_r.pop_front();
                ok = q_ok.pop_front();
                tl = q_tl.pop_front();
                tr = q_tr.pop_front();
                if (ok) begin
                    check(valid_o && !frame_err_o, "R6", "good frame strobe", valid_o, 1);
                    check(left_o == el, tl, "left sample", left_o, el);
                    check(right_o == er, tr, "right sample", right_o, er);
                    check(int'(word_len_o) == exp_wl, "R7", "word length", word_len_o, exp_wl);
                    check(word_len_o >= 5'(MINW) && word_len_o <= 5'(SW), "R8",
                          "word length range", word_len_o, exp_wl);
                    last_l = el;
                    last_r = er;
                    fp = (low_pos(el) > low_pos(er)) ? low_pos(el) : low_pos(er);
                    if (fp > win_max) win_max = fp;
                    win_cnt++;
                    if (win_cnt == WIN) begin
                        exp_wl  = (win_max < MINW) ? MINW : win_max;
                        win_cnt = 0;
                        win_max = 0;
                    end
                end else begin
                    check(frame_err_o && !valid_o, "R6", "error strobe", frame_err_o, 1);
                    check(left_o == last_l && right_o == last_r, "R6",
                          "samples held on error", left_o, last_l);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1 reset state
        check(left_o == '0, "R1", "left in reset", left_o, 0);
        check(right_o == '0, "R1", "right in reset", right_o, 0);
        check(!valid_o, "R1", "valid in reset", valid_o, 0);
        check(!frame_err_o, "R1", "error in reset", frame_err_o, 0);
        check(word_len_o == 5'd24, "R1", "word length in reset", word_len_o, 24);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;

        slot(1'b1, 1'b0);               // idle right slot before the first frame
        // directed: full words, short word, over-long word, silence
        send_frame(32'h00A5C3F1, 32'h005A3C0F, 24, 32, 32);
        check(!valid_o && !frame_err_o, "R6", "first fall starts framing only",
              valid_o, 0);
        send_frame(32'h00008001, 32'h00007FFE, 16, 32, 32);
        send_frame(32'h0FFFFFFF, 32'h01234567, 28, 32, 32);
        send_frame(32'h0, 32'h0, 24, 32, 32);
        // R6 frame length corner cases
        send_frame($urandom, $urandom, 24, 30, 32);
        send_frame($urandom, $urandom, 24, 40, 40);
        send_frame(32'h00123457, 32'h00FEDCBB, 24, 31, 33);
        send_frame($urandom, $urandom, 24, 32, 33);
        send_frame(32'h0, 32'h0, 20, 32, 32);
        send_frame(32'h0, 32'h0, 20, 32, 32);
        send_frame(32'h0, 32'h0, 20, 32, 32);
        send_frame(32'h0, 32'h0, 20, 32, 32);
        // random stream, word length changing per group
        for (int g = 0; g < 15; g++) begin
            int nb;
            nb = MINW + int'($urandom_range(0, 8));
            for (int i = 0; i < 4; i++) begin
                if ((g * 4 + i) % 13 == 7)
                    send_frame($urandom, $urandom, nb, 32, (i % 2 == 0) ? 31 : 34);
                else
                    send_frame($urandom, $urandom, nb, 32, 32);
            end
        end
        send_frame(32'h0, 32'h0, 24, 32, 32);   // closes the previous frame
        repeat (40) @(negedge clk);
        check(q_ok.size() == 1, "R5", "frames left unreported", q_ok.size(), 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule